// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Array Model

This block is a synthesizable stand-in for an asynchronous static RAM whose 16-bit data path is split into a lower and an upper byte lane. It is meant as a memory target in simulation and on an FPGA. A system clock samples the pin-level controls, so the model can be built from ordinary registers and inferred storage. The data bus stays a single bidirectional bus at the block's edge.

Two chip selects of opposite polarity, an active-low output enable, an active-low write enable and one active-low enable per byte lane set one of four modes. These are standby, selected with outputs quiet, read, and write. A write period lasts while the block is selected and write enable is low. The period ends when the first of those conditions goes away. The word, lanes and data seen at the last clock edge inside the period go into the array in the cycle that follows. A read in that cycle already returns the new data.

The external address is 20 bits wide. The stored array keeps only the low `ARRAY_AW` address bits (8 by default, 256 words), so higher address bits alias onto the same word.

Top module: `sram_bytelane_model`

## Requirements
- R1: While the block is not selected (selection needs `ce1_n` low and `ce2` high), both lanes of `dq` are high-impedance and a low `we_n` stores nothing.
- R2: While selected with `we_n` high and `oe_n` low, lane 0 (`dq[7:0]`) drives stored data only when `lb_n` is low, and lane 1 (`dq[15:8]`) only when `ub_n` is low. A lane whose enable is high stays high-impedance.
- R3: While `oe_n` is high, both lanes are high-impedance in every mode.
- R4: During a write (selected and `we_n` low), both lanes are high-impedance even when `oe_n` is low.
- R5: A write stores lane 0 only if `lb_n` was low and lane 1 only if `ub_n` was low at the last clock edge of the write period. An unwritten lane keeps its previous content.
- R6: The write period ends at whichever comes first: `we_n` rising, `ce1_n` rising or `ce2` falling. The stored word uses the address and `dq` value sampled at the last rising clock edge inside the period. Values present after the period has ended are not stored.
- R7: In the cycle right after a write period ends, a read of the same word returns the newly written lanes.
- R8: Address bits at and above `ARRAY_AW` are ignored, so two addresses that share the low `ARRAY_AW` bits select the same word.
- R9: While `rst_n` is low, no write is committed. A write period that is open when reset asserts is discarded and the stored word is unchanged.
- R10: A write period with both `lb_n` and `ub_n` high changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the controls and the write commit |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracking state |
| addr | input | 20 | Word address; only the low ARRAY_AW bits are decoded |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lb_n | input | 1 | Active-low enable for lane 0, dq[7:0] |
| ub_n | input | 1 | Active-low enable for lane 1, dq[15:8] |
| dq | inout | 16 | Bidirectional data bus, two byte lanes |

## Verification
The bench works the write period's end conditions one at a time. It ends a write with `ce2` falling, `ce1_n` rising and `we_n` rising, and changes the address, data or lane enables in the final cycle. A model that stored on the first edge, or that kept storing after deselection, would leave the wrong word or the wrong lane in the array. A read placed in the cycle right after a write catches a missing forwarding path, which would return stale data. Single-lane reads and writes, writes with both lanes disabled, writes while deselected, aliased addresses and a reset in the middle of a write each target a specific fault: a lane driven when it should float, a lane written when it should be left alone, upper address bits decoded, or a half-finished write committed.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;

  // Number of byte lanes on the data bus (lower and upper).
  localparam int LANES = 2;

  // Operating mode decoded from the control pins.
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,  // not selected
    MODE_QUIET   = 2'd1,  // selected, outputs disabled
    MODE_READ    = 2'd2,  // selected, driving enabled lanes
    MODE_WRITE   = 2'd3   // selected, write period open
  } mode_e;

  // Selection needs the low-active select low and the high-active select high.
  function automatic logic chip_selected(input logic sel_lo_n, input logic sel_hi);
    return (~sel_lo_n) & sel_hi;
  endfunction

endpackage

// File: rtl/sram_bl_decode.sv
module sram_bl_decode
  import sram_bl_pkg::*;
(
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] be_n,
  output logic             write_act,
  output logic [LANES-1:0] lane_oe
);

  mode_e mode;

  always_comb begin
    if (!chip_selected(ce1_n, ce2)) begin
      mode = MODE_STANDBY;
    end else if (!we_n) begin
      mode = MODE_WRITE;
    end else if (!oe_n) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_QUIET;
    end
  end

  assign write_act = (mode == MODE_WRITE);

  // Each lane drives only in read mode and only when its own enable is low.
  for (genvar l = 0; l < LANES; l++) begin : g_lane_oe
    assign lane_oe[l] = (mode == MODE_READ) && !be_n[l];
  end

endmodule

// File: rtl/sram_bl_wtrack.sv
module sram_bl_wtrack
  import sram_bl_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              write_act,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  lane_sel,
  output logic              commit,
  output logic [AW-1:0]     cap_idx,
  output logic [DATA_W-1:0] cap_data,
  output logic [LANES-1:0]  cap_lanes
);

  logic wact_q;

  // Keep the most recent in-period sample; the last one before the period
  // closes is what gets committed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q    <= 1'b0;
      cap_idx   <= '0;
      cap_data  <= '0;
      cap_lanes <= '0;
    end else begin
      wact_q <= write_act;
      if (write_act) begin
        cap_idx   <= idx;
        cap_data  <= din;
        cap_lanes <= lane_sel;
      end
    end
  end

  // Period was open at the last edge and is closed now.
  assign commit = wact_q & ~write_act;

endmodule

// File: rtl/sram_bl_lane.sv
module sram_bl_lane #(
  parameter int AW     = 8,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [LANE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // A pending commit to the word being read is forwarded.
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) begin
      rd_data = wr_data;
    end else begin
      rd_data = mem[rd_idx];
    end
  end

endmodule

// File: rtl/sram_bytelane_model.sv
module sram_bytelane_model
  import sram_bl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int LANE_W   = 8,
  parameter int ARRAY_AW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    oe_n,
  input  logic                    we_n,
  input  logic                    lb_n,
  input  logic                    ub_n,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]    be_n;
  logic [LANES-1:0]    lane_oe;
  logic                write_act;
  logic [ARRAY_AW-1:0] idx;
  logic [DATA_W-1:0]   din;
  logic [DATA_W-1:0]   rd_word;
  logic                commit;
  logic [ARRAY_AW-1:0] cap_idx;
  logic [DATA_W-1:0]   cap_data;
  logic [LANES-1:0]    cap_lanes;

  assign be_n = {ub_n, lb_n};
  assign idx  = addr[ARRAY_AW-1:0];
  assign din  = dq;

  // Upper address bits take no part in decoding.
  if (ADDR_W > ARRAY_AW) begin : g_alias
    logic unused_hi_addr;
    assign unused_hi_addr = ^addr[ADDR_W-1:ARRAY_AW];
  end

  sram_bl_decode u_decode (
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .be_n      (be_n),
    .write_act (write_act),
    .lane_oe   (lane_oe)
  );

  sram_bl_wtrack #(
    .AW     (ARRAY_AW),
    .DATA_W (DATA_W)
  ) u_wtrack (
    .clk       (clk),
    .rst_n     (rst_n),
    .write_act (write_act),
    .idx       (idx),
    .din       (din),
    .lane_sel  (~be_n),
    .commit    (commit),
    .cap_idx   (cap_idx),
    .cap_data  (cap_data),
    .cap_lanes (cap_lanes)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_bl_lane #(
      .AW     (ARRAY_AW),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk     (clk),
      .wr_en   (commit & cap_lanes[l]),
      .wr_idx  (cap_idx),
      .wr_data (cap_data[l*LANE_W +: LANE_W]),
      .rd_idx  (idx),
      .rd_data (rd_word[l*LANE_W +: LANE_W])
    );

    // Tri-state driver per lane.
    assign dq[l*LANE_W +: LANE_W] = lane_oe[l] ? rd_word[l*LANE_W +: LANE_W]
                                               : {LANE_W{1'bz}};
  end

endmodule

// File: rtl/sram_bytelane_checker.sv
module sram_bytelane_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ce1_n,
  input logic       ce2,
  input logic       oe_n,
  input logic       we_n,
  input logic       lb_n,
  input logic       ub_n,
  input logic [1:0] lane_oe,
  input logic       commit,
  input logic [1:0] cap_lanes
);

  logic sel;
  logic wr_open;

  assign sel     = !ce1_n && ce2;
  assign wr_open = sel && !we_n;

  // R1: deselected means no lane drives
  p_deselect_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (lane_oe == 2'b00));

  // R2: in read mode, lane drive follows the per-lane enables
  p_lane_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && !oe_n) |-> (lane_oe == {!ub_n, !lb_n}));

  // R3: output enable high keeps the bus quiet
  p_oe_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (lane_oe == 2'b00));

  // R4: no drive while a write is open
  p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |-> (lane_oe == 2'b00));

  // R5: captured lanes are those enabled at the last in-period edge
  p_lane_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |=> (cap_lanes == $past({!ub_n, !lb_n})));

  // R6: a closing write period always yields a commit
  p_commit_on_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_open |=> (wr_open || commit));

  // R6: a commit never appears while the period is still open
  p_commit_after_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!wr_open && $past(wr_open)));

  // R9: nothing is committed while reset is held
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_no_commit_in_reset_r9: assert (commit == 1'b0);
    end
  end

endmodule

bind sram_bytelane_model sram_bytelane_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .lb_n      (lb_n),
  .ub_n      (ub_n),
  .lane_oe   (lane_oe),
  .commit    (commit),
  .cap_lanes (cap_lanes)
);

// File: tb/sram_bytelane_model_bench.sv
module sram_bytelane_model_bench;

  localparam int PERIOD = 10;
  localparam int VW     = 47;

  // Vector: {we_n, ce1_n, ce2, oe_n, lb_n, ub_n, chk, req[3:0], addr[19:0], data[15:0]}
  // For checked entries data is the expected dq; a high-impedance lane reads 00
  // through the bench pulldown, so all stored bytes are non-zero.
  function automatic logic [VW-1:0] mk(input logic w, input logic c1, input logic c2,
                                       input logic o, input logic lb, input logic ub,
                                       input logic chk, input logic [3:0] req,
                                       input logic [19:0] a, input logic [15:0] d);
    return {w, c1, c2, o, lb, ub, chk, req, a, d};
  endfunction

  localparam int NV = 27;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(0,0,1,1,0,0,0,4'd5, 20'h00010, 16'hC3D4), // write full word
    mk(1,0,1,0,0,0,1,4'd7, 20'h00010, 16'hC3D4), // R7 read in commit cycle
    mk(1,0,1,0,0,0,1,4'd2, 20'h00010, 16'hC3D4), // R2 read after commit
    mk(0,0,1,1,0,1,0,4'd5, 20'h00010, 16'h1122), // lower lane write
    mk(1,0,1,0,0,0,1,4'd5, 20'h00010, 16'hC322), // R5 upper kept
    mk(0,0,1,1,1,0,0,4'd5, 20'h00010, 16'h5566), // upper lane write
    mk(1,0,1,0,0,0,1,4'd5, 20'h00010, 16'h5522), // R5 lower kept
    mk(1,0,1,0,0,1,1,4'd2, 20'h00010, 16'h0022), // R2 lower lane only
    mk(1,0,1,0,1,0,1,4'd2, 20'h00010, 16'h5500), // R2 upper lane only
    mk(1,0,1,0,1,1,1,4'd2, 20'h00010, 16'h0000), // R2 no lane enabled
    mk(1,0,1,1,0,0,1,4'd3, 20'h00010, 16'h0000), // R3 outputs disabled
    mk(0,1,1,1,0,0,0,4'd1, 20'h00010, 16'h9999), // write while ce1_n high
    mk(1,0,1,0,0,0,1,4'd1, 20'h00010, 16'h5522), // R1 unchanged
    mk(0,0,0,1,0,0,0,4'd1, 20'h00010, 16'h8888), // write while ce2 low
    mk(1,0,1,0,0,0,1,4'd1, 20'h00010, 16'h5522), // R1 unchanged
    mk(1,1,1,0,0,0,1,4'd1, 20'h00010, 16'h0000), // R1 deselected read floats
    mk(1,0,0,0,0,0,1,4'd1, 20'h00010, 16'h0000), // R1 ce2 low read floats
    mk(0,0,1,1,0,0,0,4'd10,20'h000FF, 16'h1357), // write base
    mk(1,0,1,0,0,0,1,4'd10,20'h000FF, 16'h1357),
    mk(0,0,1,1,1,1,0,4'd10,20'h000FF, 16'h7777), // write, no lanes
    mk(1,0,1,1,0,0,0,4'd10,20'h000FF, 16'h0000), // close period
    mk(1,0,1,0,0,0,1,4'd10,20'h000FF, 16'h1357), // R10 unchanged
    mk(0,0,1,1,0,0,0,4'd8, 20'hF203A, 16'h2468), // write via high alias
    mk(1,0,1,0,0,0,1,4'd8, 20'h0003A, 16'h2468), // R8 read low alias
    mk(0,0,1,1,0,0,0,4'd8, 20'h0013A, 16'h9ABC), // write another alias
    mk(1,0,1,1,0,0,0,4'd8, 20'h0003A, 16'h0000), // close period
    mk(1,0,1,0,0,0,1,4'd8, 20'h5A03A, 16'h9ABC)  // R8 read third alias
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic        ce1_n = 1'b1;
  logic        ce2 = 1'b0;
  logic        oe_n = 1'b1;
  logic        we_n = 1'b1;
  logic        lb_n = 1'b1;
  logic        ub_n = 1'b1;
  logic        tb_drv = 1'b0;
  logic [15:0] tb_val = '0;
  wire  [15:0] dq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  assign dq = tb_drv ? tb_val : 16'hzzzz;

  for (genvar b = 0; b < 16; b++) begin : g_pd
    pulldown (dq[b]);
  end

  always #(PERIOD/2) clk = ~clk;

  sram_bytelane_model u_sram_bytelane_model (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .ce1_n (ce1_n),
    .ce2   (ce2),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .lb_n  (lb_n),
    .ub_n  (ub_n),
    .dq    (dq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic pins(input logic w, input logic c1, input logic c2, input logic o,
                      input logic lb, input logic ub, input logic [19:0] a,
                      input logic [15:0] d, input logic drv);
    we_n = w; ce1_n = c1; ce2 = c2; oe_n = o; lb_n = lb; ub_n = ub;
    addr = a; tb_val = d; tb_drv = drv;
  endtask

  // One-cycle full write, then close the period with we_n high.
  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk); pins(0,0,1,1,0,0,a,d,1);
    @(negedge clk); pins(1,0,1,1,0,0,a,16'h0,0);
  endtask

  task automatic rd(input logic [19:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); pins(1,0,1,0,0,0,a,16'h0,0);
    #2 check(req, dq, exp);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: deselected, bus floats (R9, R1)
    repeat (3) @(negedge clk);
    #2 check("R9 reset idle", dq, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk); #2 check("R1 idle after reset", dq, 16'h0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      pins(v[46], v[45], v[44], v[43], v[42], v[41], v[35:16], v[15:0], !v[46]);
      #2;
      if (v[40]) check($sformatf("R%0d vec%0d", v[39:36], i), dq, v[15:0]);
    end

    // R6: period closed by ce2 falling; data after close ignored
    @(negedge clk); pins(0,0,1,1,0,0,20'h00020,16'h1111,1);
    @(negedge clk); pins(0,0,1,1,0,0,20'h00020,16'h2222,1);
    @(negedge clk); pins(0,0,1,1,0,0,20'h00020,16'h3333,1);
    @(negedge clk); pins(0,0,0,1,0,0,20'h00020,16'h4444,1);
    rd(20'h00020, 16'h3333, "R6 close by ce2");

    // R6: period closed by ce1_n rising; address moved in last cycle
    wr(20'h00022, 16'hCCCC);
    @(negedge clk); pins(0,0,1,1,0,0,20'h00022,16'hAAAA,1);
    @(negedge clk); pins(0,0,1,1,0,0,20'h00021,16'hBBBB,1);
    @(negedge clk); pins(0,1,1,1,0,0,20'h00021,16'hDDDD,1);
    rd(20'h00021, 16'hBBBB, "R6 close by ce1_n, last address");
    rd(20'h00022, 16'hCCCC, "R6 earlier address untouched");

    // R5/R7: upper lane dropped in final cycle, read in commit cycle
    wr(20'h00024, 16'h5A5A);
    @(negedge clk); pins(0,0,1,1,0,0,20'h00024,16'h1E2F,1);
    @(negedge clk); pins(0,0,1,1,0,1,20'h00024,16'h1E2F,1);
    @(negedge clk); pins(1,0,1,0,0,0,20'h00024,16'h0,0);
    #2 check("R7 forwarded in commit cycle", dq, 16'h5A2F);
    rd(20'h00024, 16'h5A2F, "R5 final-cycle lanes only");

    // R4: write with oe_n low and bench not driving: bus must float
    wr(20'h00030, 16'hF0F0);
    @(negedge clk); pins(0,0,1,0,0,0,20'h00030,16'h0,0);
    #2 check("R4 no drive during write", dq, 16'h0000);
    @(negedge clk); pins(1,0,1,1,0,0,20'h00030,16'h0,0);

    // R9: reset while a write period is open
    wr(20'h00040, 16'h1234);
    rd(20'h00040, 16'h1234, "R9 setup");
    @(negedge clk); pins(0,0,1,1,0,0,20'h00040,16'h5678,1);
    @(negedge clk); rst_n = 1'b0; pins(1,0,1,1,0,0,20'h00040,16'h0,0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(20'h00040, 16'h1234, "R9 open write discarded");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule